// File: doc/BRIEF.md
# Coin-Accumulating Vending Controller

This block is a synchronous state machine that adds up coins toward a fixed price of 35 cents. When the price is met or exceeded, it releases one item and reports the change owed. Three one-hot lines tell it which coin is presented: a 5-cent nickel, a 10-cent dime or a 25-cent quarter. A separate register strobe commits the presented coin. The machine answers with a one-cycle `vend` pulse and a change amount counted in 5-cent units.

Internally, money is tracked in 5-cent units. Seven credit states cover every total below the price: `CR_00`, `CR_05`, `CR_10`, `CR_15`, `CR_20`, `CR_25` and `CR_30`. Five dispense states cover the totals that can be reached by adding one coin to a credit state: `FN_35`, `FN_40`, `FN_45`, `FN_50` and `FN_55`.

The transitions are as follows:
- **Accumulate:** from a credit state, an accepted coin moves to the credit state for the new total when that total is below 35 cents.
- **Dispense:** from a credit state, when the new total is 35 cents or more, an accepted coin moves to the matching `FN_*` state.
- **Restart:** from an `FN_*` state, an accepted coin moves to the credit state equal to that coin's value alone.
- **Hold:** with no accepted coin, the state does not change.

Top module: `vend_ctrl`

## Requirements
- R1: A synchronous active-high `rst` puts the machine in `CR_00` with `vend` low and `change_units` zero. A strobe held high through reset is not counted when reset is released.
- R2: An accepted coin adds its value to the credit. The coin lines are nickel = 1 unit, dime = 2 units and quarter = 5 units, where one unit is 5 cents.
- R3: A coin is accepted only on a rising edge of `reg_btn`. Holding the strobe high for several cycles counts the coin once.
- R4: A strobe edge with no coin line high, or with two or more coin lines high, is ignored. The credit is unchanged.
- R5: When an accepted coin brings the total to 7 units (35 cents) or more, `vend` is high for exactly one cycle. That cycle is the clock cycle after the edge at which the strobe was first seen high.
- R6: In the `vend` cycle, `change_units` equals the total minus 7 units, which is a value from 0 to 4. In every other cycle it is zero.
- R7: The first accepted coin after a dispense starts a new credit equal to that coin's value.
- R8: While the total stays below 7 units, `vend` remains low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| coin_nickel | input | 1 | Nickel presented |
| coin_dime | input | 1 | Dime presented |
| coin_quarter | input | 1 | Quarter presented |
| reg_btn | input | 1 | Register strobe; a rising edge commits the presented coin |
| vend | output | 1 | One-cycle item release pulse |
| change_units | output | 3 | Change owed in 5-cent units, valid in the `vend` cycle |

## Verification
The properties assume the following about the inputs:
- The coin lines are stable in the cycle the strobe edge is sampled.
- Reset is asserted from time zero, so the lookback to the previous cycle in the strobe properties never reaches a value from before reset.

The stimulus keeps within these assumptions. It changes coin lines and strobe together at the falling clock edge and holds reset for two cycles at the start. The stimulus then sweeps every reachable credit against all eight coin-line patterns. After each sweep step it flushes the remaining credit with quarters, so that an ignored or wrongly counted coin shows up in the change value.

// File: rtl/vend_pkg.sv
package vend_pkg;
    localparam int PRICE_U     = 7;
    localparam int NICKEL_U    = 1;
    localparam int DIME_U      = 2;
    localparam int QUARTER_U   = 5;
    localparam int MAX_TOTAL_U = PRICE_U - 1 + QUARTER_U;
    localparam int CHG_MAX_U   = MAX_TOTAL_U - PRICE_U;
    localparam int CHG_W       = $clog2(CHG_MAX_U + 1);
    localparam int VAL_W       = $clog2(QUARTER_U + 1);
    localparam int ST_W        = $clog2(MAX_TOTAL_U + 1);

    // State code equals the running total in 5-cent units.
    typedef enum logic [ST_W-1:0] {
        CR_00 = ST_W'(0),
        CR_05 = ST_W'(1),
        CR_10 = ST_W'(2),
        CR_15 = ST_W'(3),
        CR_20 = ST_W'(4),
        CR_25 = ST_W'(5),
        CR_30 = ST_W'(6),
        FN_35 = ST_W'(7),
        FN_40 = ST_W'(8),
        FN_45 = ST_W'(9),
        FN_50 = ST_W'(10),
        FN_55 = ST_W'(11)
    } vend_state_e;

    typedef struct packed {
        logic quarter;
        logic dime;
        logic nickel;
    } coin_t;
endpackage

// File: rtl/vend_strobe_edge.sv
module vend_strobe_edge (
    input  logic clk,
    input  logic rst,
    input  logic btn,
    output logic pulse
);
    logic btn_q;

    // Loaded high in reset so a press held through reset is not counted.
    always_ff @(posedge clk) begin
        if (rst) btn_q <= 1'b1;
        else     btn_q <= btn;
    end

    assign pulse = btn & ~btn_q;
endmodule

// File: rtl/vend_coin_value.sv
module vend_coin_value
    import vend_pkg::*;
(
    input  coin_t            coins,
    output logic             valid,
    output logic [VAL_W-1:0] units
);
    always_comb begin
        valid = 1'b0;
        units = '0;
        unique case (coins)
            3'b001: begin valid = 1'b1; units = VAL_W'(NICKEL_U);  end
            3'b010: begin valid = 1'b1; units = VAL_W'(DIME_U);    end
            3'b100: begin valid = 1'b1; units = VAL_W'(QUARTER_U); end
            default: begin valid = 1'b0; units = '0; end
        endcase
    end
endmodule

// File: rtl/vend_fsm.sv
module vend_fsm
    import vend_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic [VAL_W-1:0] coin_u,
    output logic             vend,
    output logic [CHG_W-1:0] change_u
);
    vend_state_e         state, state_nx;
    logic [ST_W-1:0]     base_u;
    logic [ST_W-1:0]     total_u;
    logic                cur_final;
    logic                nx_final;

    // Credit carried into the next coin; dispense states restart at zero.
    always_comb begin
        base_u    = '0;
        cur_final = 1'b0;
        unique case (state)
            CR_00, CR_05, CR_10, CR_15,
            CR_20, CR_25, CR_30: begin
                base_u    = state;
                cur_final = 1'b0;
            end
            FN_35, FN_40, FN_45, FN_50, FN_55: begin
                base_u    = '0;
                cur_final = 1'b1;
            end
            default: begin
                base_u    = '0;
                cur_final = 1'b0;
            end
        endcase
    end

    always_comb begin
        total_u  = base_u + ST_W'(coin_u);
        state_nx = accept ? vend_state_e'(total_u) : state;
        nx_final = (state_nx >= FN_35);
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) state <= CR_00;
        else     state <= state_nx;
    end

    // Outputs: pulse on entry to a dispense state.
    always_ff @(posedge clk) begin
        if (rst) begin
            vend     <= 1'b0;
            change_u <= '0;
        end else if (nx_final && !cur_final) begin
            vend     <= 1'b1;
            change_u <= CHG_W'(total_u - ST_W'(PRICE_U));
        end else begin
            vend     <= 1'b0;
            change_u <= '0;
        end
    end
endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
    import vend_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             coin_nickel,
    input  logic             coin_dime,
    input  logic             coin_quarter,
    input  logic             reg_btn,
    output logic             vend,
    output logic [CHG_W-1:0] change_units
);
    logic             strobe;
    logic             coin_ok;
    logic [VAL_W-1:0] coin_u;
    coin_t            coins;

    assign coins = '{quarter: coin_quarter, dime: coin_dime, nickel: coin_nickel};

    vend_strobe_edge u_edge (
        .clk   (clk),
        .rst   (rst),
        .btn   (reg_btn),
        .pulse (strobe)
    );

    vend_coin_value u_value (
        .coins (coins),
        .valid (coin_ok),
        .units (coin_u)
    );

    vend_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .accept   (strobe & coin_ok),
        .coin_u   (coin_u),
        .vend     (vend),
        .change_u (change_units)
    );
endmodule

// File: rtl/vend_ctrl_chk.sv
module vend_ctrl_chk
    import vend_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             coin_nickel,
    input logic             coin_dime,
    input logic             coin_quarter,
    input logic             reg_btn,
    input logic             vend,
    input logic [CHG_W-1:0] change_units
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!vend && change_units == '0));

    assert_held_once_R3: assert property (@(posedge clk) disable iff (rst)
        ($past(reg_btn) && reg_btn) |=> !vend);

    assert_vend_needs_edge_R3: assert property (@(posedge clk) disable iff (rst)
        vend |-> ($past(reg_btn) && $onehot($past({coin_quarter, coin_dime, coin_nickel}))));

    assert_bad_coin_ignored_R4: assert property (@(posedge clk) disable iff (rst)
        (reg_btn && !$onehot({coin_quarter, coin_dime, coin_nickel})) |=> !vend);

    assert_vend_single_R5: assert property (@(posedge clk) disable iff (rst)
        vend |=> !vend);

    assert_change_idle_R6: assert property (@(posedge clk) disable iff (rst)
        !vend |-> (change_units == '0));

    assert_change_range_R6: assert property (@(posedge clk) disable iff (rst)
        vend |-> (change_units <= CHG_W'(CHG_MAX_U)));
endmodule

bind vend_ctrl vend_ctrl_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .coin_nickel  (coin_nickel),
    .coin_dime    (coin_dime),
    .coin_quarter (coin_quarter),
    .reg_btn      (reg_btn),
    .vend         (vend),
    .change_units (change_units)
);

// File: tb/sim_vend_ctrl.sv
module sim_vend_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int PRICE      = 7;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] coins = 3'b000;   // {quarter, dime, nickel}
    logic       btn = 1'b0;
    logic       vend;
    logic [2:0] change_units;

    int n_tests = 0;
    int n_fail  = 0;
    int model   = 0;
    bit after_final = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vend_ctrl u0 (
        .clk          (clk),
        .rst          (rst),
        .coin_nickel  (coins[0]),
        .coin_dime    (coins[1]),
        .coin_quarter (coins[2]),
        .reg_btn      (btn),
        .vend         (vend),
        .change_units (change_units)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; btn = 1'b1; coins = 3'b000;
        @(negedge clk);
        @(negedge clk);
        check(vend == 1'b0, "R1 vend in reset", int'(vend), 0);
        check(change_units == 3'd0, "R1 change in reset", int'(change_units), 0);
        btn = 1'b0;
        rst = 1'b0;
        model = 0;
        after_final = 1'b0;
        @(negedge clk);
        check(vend == 1'b0, "R1 vend after reset", int'(vend), 0);
    endtask

    task automatic press(input logic [2:0] mask, input int hold);
        bit    valid;
        int    val;
        int    sum;
        bit    exp_v;
        int    exp_c;
        string tag;
        valid = (mask == 3'b001) || (mask == 3'b010) || (mask == 3'b100);
        val   = (mask == 3'b001) ? 1 : (mask == 3'b010) ? 2 : (mask == 3'b100) ? 5 : 0;
        sum   = model + val;
        exp_v = valid && (sum >= PRICE);
        exp_c = exp_v ? sum - PRICE : 0;
        if (!valid)        tag = "R4";
        else if (exp_v)    tag = "R5";
        else if (after_final) tag = "R7";
        else               tag = "R8";
        @(negedge clk);
        coins = mask; btn = 1'b1;
        @(negedge clk);
        check(vend == exp_v, {tag, " vend"}, int'(vend), int'(exp_v));
        check(int'(change_units) == exp_c, "R6 change", int'(change_units), exp_c);
        for (int h = 1; h < hold; h++) begin
            @(negedge clk);
            check(vend == 1'b0, "R3 held strobe", int'(vend), 0);
        end
        coins = 3'b000; btn = 1'b0;
        @(negedge clk);
        check(vend == 1'b0, "R5 single cycle", int'(vend), 0);
        check(change_units == 3'd0, "R6 change idle", int'(change_units), 0);
        if (valid) begin
            model = exp_v ? 0 : sum;
            after_final = exp_v;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // R2/R4/R5/R6/R7/R8: every credit against every coin-line pattern.
        for (int s = 0; s < PRICE; s++) begin
            for (int m = 0; m < 8; m++) begin
                do_reset();
                for (int k = 0; k < s; k++) press(3'b001, 1);
                press(3'(m), 1);
                press(3'b100, 1);
                press(3'b100, 1);
            end
        end
        // R3: held strobe counts once; credit proven by the flush change.
        do_reset();
        press(3'b010, 5);
        press(3'b100, 1);
        // R7: back-to-back transactions, each starting from the restart coin.
        do_reset();
        press(3'b100, 1);
        press(3'b100, 1);
        press(3'b010, 1);
        press(3'b010, 1);
        press(3'b100, 1);
        // R1: reset mid-transaction clears credit.
        do_reset();
        press(3'b100, 1);
        do_reset();
        press(3'b010, 1);
        press(3'b001, 1);
        press(3'b100, 1);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule